// File: doc/BRIEF.md
# Rotor Cipher Character Sequencer

The block enciphers one 5-bit character (code values 0 to 25) per pass with a rotor-style substitution. A one-cycle strobe on `newChar` while the block is idle captures `charIn` and starts a fixed-length pass. The character optionally passes through a writable pairing table (the plugboard). It then passes forward through `NUM_WHEELS` wheel stages and through a fixed reflector. After that it passes back through the same wheels in the reverse order with their inverse wiring, then through the plugboard again. The result is registered on `charOut` together with a one-cycle `done` pulse.

Wheel positions are supplied from outside on `wheelPos` by a separate stepping counter. The block reads them during the pass and does not change them. The wheel wiring and the reflector wiring are constant tables held in separate ROMs. An operation FSM sequences the pass. It hands the wheel portion to a subordinate FSM that walks the stages three cycles at a time. Because the reflector is an involution with no fixed point, the whole map is its own inverse for fixed positions and plugboard: sending the output back through the block returns the original character.

Top module: `rotor_cipher_seq`

## Requirements
- R1: After a synchronous reset `busy`, `done` and `charOut` are 0, and every plugboard entry maps a code to itself.
- R2: A strobe accepted at a rising edge while idle makes `busy` high from the next cycle. `charOut` and `done` update at the (5 + 6·NUM_WHEELS)-th rising edge after the accepting edge, which is the 17th edge for two wheels. `busy` is low again in that same cycle.
- R3: `done` is high for exactly one cycle per pass. `charOut` holds its value between passes.
- R4: A `newChar` strobe while `busy` is high is ignored. It produces no extra result and does not change the result or the timing of the running pass.
- R5: For fixed `wheelPos` and plugboard contents, enciphering the output character returns the original input.
- R6: No input code in 0..25 ever produces itself on `charOut`.
- R7: With `plugEn` low both plugboard steps pass the character through unchanged, and the pass length is unchanged.
- R8: A write with `plugWrEn` high sets entry `plugWrAddr` to `plugWrData` at the next edge. Addresses 26..31 are ignored. A plugboard step replaces code c by entry c.
- R9: Wheel stage w with position p maps c to (F_w((c+p) mod 26) − p) mod 26 on the forward pass and uses F_w⁻¹ on the return pass. Here F_w(x) = (m_w·x + k_w) mod 26, k_w = (7w+5) mod 26, and m_w = 3+2·(w mod 11), plus 2 more when that value is 13 or above. Wheel w reads `wheelPos[5w+4:5w]`.
- R10: The stage order is plugboard, wheels 0 up to NUM_WHEELS−1, reflector, wheels NUM_WHEELS−1 down to 0, plugboard. The reflector maps c to (H((c+13) mod 26) + 13) mod 26 with H(x) = x XOR 1.
- R11: A strobe given in the cycle where `done` is high is accepted, so characters can stream back to back with no gap cycle.
- R12: `done` and `busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| newChar | input | 1 | Start strobe, sampled while idle |
| charIn | input | 5 | Character code to encipher, 0..25 |
| plugEn | input | 1 | High applies the plugboard in both swap steps |
| plugWrEn | input | 1 | Plugboard entry write enable |
| plugWrAddr | input | 5 | Plugboard entry to write |
| plugWrData | input | 5 | Value written to the entry |
| wheelPos | input | 5·NUM_WHEELS | Wheel positions, wheel w in bits 5w+4..5w |
| busy | output | 1 | High while a pass is running |
| done | output | 1 | One-cycle pulse with a new result |
| charOut | output | 5 | Registered result character |

## Verification
The hardest situation to reach from the ports is an overlap at the edges of a pass. One case is a strobe that arrives while a pass is running. The other is a strobe that lands exactly in the `done` cycle and must start the next pass with no gap. The stimulus pokes a second strobe into the middle of a pass with a different character, then shows through the scoreboard that only one result comes out, at the original time and with the original value. Stream runs then issue each strobe as soon as `busy` falls and confirm that `done` was high at that moment. Reciprocity is checked by feeding a result back in with the same positions and a non-identity plugboard.

// File: rtl/rc_pkg.sv
package rc_pkg;

  localparam int CW        = 5;
  localparam int MODV      = 26;
  localparam int TAB_DEPTH = 32;
  localparam int REFL_ROT  = 13;

  typedef struct packed {
    logic capture;
    logic load;
    logic plugSwap;
    logic offAdd;
    logic romLook;
    logic offSub;
    logic reflect;
    logic inverse;
    logic outLatch;
  } rc_strobe_t;

  function automatic logic [CW-1:0] add26(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (CW+1)'(MODV)) s = s - (CW+1)'(MODV);
    return s[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] sub26(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + (CW+1)'(MODV) - {1'b0, b};
    return s[CW-1:0];
  endfunction

  function automatic int wheelMul(input int w);
    int m;
    m = 3 + 2 * (w % 11);
    if (m >= 13) m = m + 2;
    return m;
  endfunction

  function automatic int wheelOff(input int w);
    return (7 * w + 5) % MODV;
  endfunction

  function automatic logic [CW-1:0] wheelFwd(input int w, input int a);
    int v;
    if (a >= MODV) v = a;
    else v = (wheelMul(w) * a + wheelOff(w)) % MODV;
    return CW'(v);
  endfunction

  function automatic logic [CW-1:0] wheelInv(input int w, input int a);
    int r;
    r = a;
    if (a < MODV) begin
      for (int y = 0; y < MODV; y++) begin
        if (wheelFwd(w, y) == CW'(a)) r = y;
      end
    end
    return CW'(r);
  endfunction

  function automatic logic [CW-1:0] reflPair(input int a);
    int v;
    if (a >= MODV) v = a;
    else v = a ^ 1;
    return CW'(v);
  endfunction

endpackage

// File: rtl/rc_wheel_seq.sv
module rc_wheel_seq #(
  parameter int NUM_WHEELS = 2,
  parameter int IDX_W      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             startRev,
  output logic             active,
  output logic             rev,
  output logic [1:0]       step,
  output logic [IDX_W-1:0] wheelIdx,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WHEELS - 1);

  logic lastWheel;

  assign lastWheel = rev ? (wheelIdx == '0) : (wheelIdx == LAST_IDX);
  assign last      = active && (step == 2'd2) && lastWheel;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      rev      <= 1'b0;
      step     <= 2'd0;
      wheelIdx <= '0;
    end else if (start) begin
      active   <= 1'b1;
      rev      <= startRev;
      step     <= 2'd0;
      wheelIdx <= startRev ? LAST_IDX : '0;
    end else if (active) begin
      if (step == 2'd2) begin
        step <= 2'd0;
        if (lastWheel) active <= 1'b0;
        else wheelIdx <= rev ? (wheelIdx - 1'b1) : (wheelIdx + 1'b1);
      end else begin
        step <= step + 2'd1;
      end
    end
  end

endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl #(
  parameter int NUM_WHEELS = 2,
  parameter int IDX_W      = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               newChar,
  output logic               busy,
  output rc_pkg::rc_strobe_t strobe,
  output logic [IDX_W-1:0]   wheelIdx
);

  typedef enum logic [2:0] {
    OP_IDLE, OP_LOAD, OP_PLUG_IN, OP_WHEEL_FWD,
    OP_REFL, OP_WHEEL_REV, OP_PLUG_OUT, OP_OUT
  } op_state_t;

  op_state_t state, nextState;

  logic       subStart, subStartRev, subActive, subRev, subLast;
  logic [1:0] subStep;

  assign subStart    = (state == OP_PLUG_IN) || (state == OP_REFL);
  assign subStartRev = (state == OP_REFL);

  rc_wheel_seq #(.NUM_WHEELS(NUM_WHEELS), .IDX_W(IDX_W)) u_wheelSeq (
    .clk      (clk),
    .rst      (rst),
    .start    (subStart),
    .startRev (subStartRev),
    .active   (subActive),
    .rev      (subRev),
    .step     (subStep),
    .wheelIdx (wheelIdx),
    .last     (subLast)
  );

  always_comb begin
    nextState = state;
    case (state)
      OP_IDLE:      if (newChar) nextState = OP_LOAD;
      OP_LOAD:      nextState = OP_PLUG_IN;
      OP_PLUG_IN:   nextState = OP_WHEEL_FWD;
      OP_WHEEL_FWD: if (subLast) nextState = OP_REFL;
      OP_REFL:      nextState = OP_WHEEL_REV;
      OP_WHEEL_REV: if (subLast) nextState = OP_PLUG_OUT;
      OP_PLUG_OUT:  nextState = OP_OUT;
      OP_OUT:       nextState = OP_IDLE;
      default:      nextState = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= OP_IDLE;
    else     state <= nextState;
  end

  assign busy = (state != OP_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.capture  = (state == OP_IDLE) && newChar;
    strobe.load     = (state == OP_LOAD);
    strobe.plugSwap = (state == OP_PLUG_IN) || (state == OP_PLUG_OUT);
    strobe.reflect  = (state == OP_REFL);
    strobe.outLatch = (state == OP_OUT);
    strobe.offAdd   = subActive && (subStep == 2'd0);
    strobe.romLook  = subActive && (subStep == 2'd1);
    strobe.offSub   = subActive && (subStep == 2'd2);
    strobe.inverse  = subRev;
  end

endmodule

// File: rtl/rc_datapath.sv
module rc_datapath #(
  parameter int NUM_WHEELS = 2,
  parameter int IDX_W      = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  rc_pkg::rc_strobe_t              strobe,
  input  logic [IDX_W-1:0]                wheelIdx,
  input  logic [rc_pkg::CW-1:0]           charIn,
  input  logic                            plugEn,
  input  logic                            plugWrEn,
  input  logic [rc_pkg::CW-1:0]           plugWrAddr,
  input  logic [rc_pkg::CW-1:0]           plugWrData,
  input  logic [NUM_WHEELS*rc_pkg::CW-1:0] wheelPos,
  output logic                            done,
  output logic [rc_pkg::CW-1:0]           charOut
);

  import rc_pkg::*;

  localparam int SLOTS = 1 << IDX_W;

  logic [CW-1:0] fwdTab  [SLOTS][TAB_DEPTH];
  logic [CW-1:0] invTab  [SLOTS][TAB_DEPTH];
  logic [CW-1:0] reflTab [TAB_DEPTH];
  logic [CW-1:0] posArr  [SLOTS];
  logic [CW-1:0] plugTab [TAB_DEPTH];

  logic [CW-1:0] work, inLatch, posSel, romOut, reflAddr, reflOut, plugOut;

  for (genvar w = 0; w < SLOTS; w++) begin : g_wheel
    if (w < NUM_WHEELS) begin : g_pos
      assign posArr[w] = wheelPos[w*CW +: CW];
    end else begin : g_pad
      assign posArr[w] = '0;
    end
    for (genvar a = 0; a < TAB_DEPTH; a++) begin : g_rom
      assign fwdTab[w][a] = wheelFwd(w, a);
      assign invTab[w][a] = wheelInv(w, a);
    end
  end

  for (genvar a = 0; a < TAB_DEPTH; a++) begin : g_refl
    assign reflTab[a] = reflPair(a);
  end

  assign posSel   = posArr[wheelIdx];
  assign romOut   = strobe.inverse ? invTab[wheelIdx][work] : fwdTab[wheelIdx][work];
  assign reflAddr = add26(work, CW'(REFL_ROT));
  assign reflOut  = add26(reflTab[reflAddr], CW'(REFL_ROT));
  assign plugOut  = plugEn ? plugTab[work] : work;

  always_ff @(posedge clk) begin
    if (rst) begin
      work    <= '0;
      inLatch <= '0;
      charOut <= '0;
      done    <= 1'b0;
      for (int i = 0; i < TAB_DEPTH; i++) plugTab[i] <= CW'(i);
    end else begin
      done <= 1'b0;
      if (plugWrEn && (plugWrAddr < CW'(MODV))) plugTab[plugWrAddr] <= plugWrData;
      if (strobe.capture)  inLatch <= charIn;
      if (strobe.load)     work    <= inLatch;
      if (strobe.plugSwap) work    <= plugOut;
      if (strobe.offAdd)   work    <= add26(work, posSel);
      if (strobe.romLook)  work    <= romOut;
      if (strobe.offSub)   work    <= sub26(work, posSel);
      if (strobe.reflect)  work    <= reflOut;
      if (strobe.outLatch) begin
        charOut <= work;
        done    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rotor_cipher_seq.sv
module rotor_cipher_seq #(
  parameter int NUM_WHEELS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   newChar,
  input  logic [4:0]             charIn,
  input  logic                   plugEn,
  input  logic                   plugWrEn,
  input  logic [4:0]             plugWrAddr,
  input  logic [4:0]             plugWrData,
  input  logic [NUM_WHEELS*5-1:0] wheelPos,
  output logic                   busy,
  output logic                   done,
  output logic [4:0]             charOut
);

  localparam int IDX_W = (NUM_WHEELS > 1) ? $clog2(NUM_WHEELS) : 1;

  rc_pkg::rc_strobe_t strobe;
  logic [IDX_W-1:0]   wheelIdx;

  rc_ctrl #(.NUM_WHEELS(NUM_WHEELS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .newChar  (newChar),
    .busy     (busy),
    .strobe   (strobe),
    .wheelIdx (wheelIdx)
  );

  rc_datapath #(.NUM_WHEELS(NUM_WHEELS), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .wheelIdx   (wheelIdx),
    .charIn     (charIn),
    .plugEn     (plugEn),
    .plugWrEn   (plugWrEn),
    .plugWrAddr (plugWrAddr),
    .plugWrData (plugWrData),
    .wheelPos   (wheelPos),
    .done       (done),
    .charOut    (charOut)
  );

endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int NUM_WHEELS = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       newChar,
  input logic [4:0] charIn,
  input logic       busy,
  input logic       done,
  input logic [4:0] charOut
);

  localparam int PASS_LEN = 5 + 6 * NUM_WHEELS;
  localparam int CNT_W    = $clog2(PASS_LEN + 2);

  logic [CNT_W-1:0] busyCnt;
  logic [4:0]       inHold;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyCnt <= '0;
      inHold  <= '0;
    end else begin
      busyCnt <= busy ? busyCnt + 1'b1 : '0;
      if (!busy && newChar) inHold <= charIn;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (!busy && !done && charOut == 5'd0));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst) (!busy && newChar) |=> busy);

  assert_done_at_end_R2: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  assert_hold_out_R3: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(charOut));

  // R4: a strobe during a pass neither stretches nor restarts it
  assert_pass_len_R4: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (busyCnt == CNT_W'(PASS_LEN)));

  assert_no_fixed_point_R6: assert property (@(posedge clk) disable iff (rst) done |-> (charOut != inHold));

  assert_done_busy_excl_R12: assert property (@(posedge clk) disable iff (rst) !(done && busy));

endmodule

bind rotor_cipher_seq rc_checker #(.NUM_WHEELS(NUM_WHEELS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .newChar (newChar),
  .charIn  (charIn),
  .busy    (busy),
  .done    (done),
  .charOut (charOut)
);

// File: tb/sim_rotor_cipher_seq.sv
`timescale 1ns/1ps
module sim_rotor_cipher_seq;

  localparam int NW       = 2;
  localparam int PASS_LEN = 5 + 6 * NW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          newChar = 1'b0;
  logic [4:0]    charIn = '0;
  logic          plugEn = 1'b1;
  logic          plugWrEn = 1'b0;
  logic [4:0]    plugWrAddr = '0;
  logic [4:0]    plugWrData = '0;
  logic [NW*5-1:0] wheelPos = '0;
  logic          busy, done;
  logic [4:0]    charOut;

  rotor_cipher_seq #(.NUM_WHEELS(NW)) u0 (
    .clk(clk), .rst(rst), .newChar(newChar), .charIn(charIn), .plugEn(plugEn),
    .plugWrEn(plugWrEn), .plugWrAddr(plugWrAddr), .plugWrData(plugWrData),
    .wheelPos(wheelPos), .busy(busy), .done(done), .charOut(charOut)
  );

  always #4 clk = ~clk;

  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    int    expOut;
    int    inChar;
    int    expCycle;
    string req;
  } sb_item_t;

  sb_item_t sbq[$];

  int plugM [26];
  int posM  [NW];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  function automatic int mMul(int w);
    int m;
    m = 3 + 2 * (w % 11);
    if (m >= 13) m = m + 2;
    return m;
  endfunction

  function automatic int mFwd(int w, int x);
    return (mMul(w) * x + (7 * w + 5) % 26) % 26;
  endfunction

  function automatic int mInv(int w, int x);
    int r = 0;
    for (int y = 0; y < 26; y++) if (mFwd(w, y) == x) r = y;
    return r;
  endfunction

  function automatic int modelPass(int c0);
    int c, t;
    c = c0;
    if (plugEn) c = plugM[c];
    for (int w = 0; w < NW; w++) begin
      t = mFwd(w, (c + posM[w]) % 26);
      c = (t - posM[w] + 26) % 26;
    end
    c = (((c + 13) % 26) ^ 1);
    c = (c + 13) % 26;
    for (int w = NW - 1; w >= 0; w--) begin
      t = mInv(w, (c + posM[w]) % 26);
      c = (t - posM[w] + 26) % 26;
    end
    if (plugEn) c = plugM[c];
    return c;
  endfunction

  task automatic setPos(input int p0, input int p1);
    posM[0] = p0;
    posM[1] = p1;
    wheelPos = {5'(p1), 5'(p0)};
  endtask

  task automatic doReset;
    rst = 1'b1;
    newChar = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 26; i++) plugM[i] = i;
    sbq.delete();
  endtask

  task automatic sendChar(input int c, input string req, input bit stream);
    while (busy) @(negedge clk);
    if (stream) check(done == 1'b1, "R11", int'(done), 1);
    charIn = 5'(c);
    newChar = 1'b1;
    sbq.push_back('{modelPass(c), c, cycle + 1 + PASS_LEN, req});
    @(negedge clk);
    newChar = 1'b0;
  endtask

  task automatic pokeStrobe(input int c);
    charIn = 5'(c);
    newChar = 1'b1;
    @(negedge clk);
    newChar = 1'b0;
  endtask

  task automatic plugPair(input int a, input int b);
    plugWrEn = 1'b1;
    plugWrAddr = 5'(a); plugWrData = 5'(b);
    @(negedge clk);
    plugWrAddr = 5'(b); plugWrData = 5'(a);
    @(negedge clk);
    plugWrEn = 1'b0;
    plugM[a] = b;
    plugM[b] = a;
  endtask

  task automatic waitIdle;
    while (busy || sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard on each result
  bit prevDone = 1'b0;
  int extraDone = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prevDone) check(done == 1'b0, "R3", int'(done), 0);
      if (done) begin
        check(busy == 1'b0, "R12", int'(busy), 0);
        if (sbq.size() == 0) begin
          extraDone++;
          check(1'b0, "R4", int'(charOut), -1);
        end else begin
          sb_item_t it;
          it = sbq.pop_front();
          check(int'(charOut) == it.expOut, it.req, int'(charOut), it.expOut);
          check(cycle == it.expCycle, "R2", cycle, it.expCycle);
          check(int'(charOut) != it.inChar, "R6", int'(charOut), it.inChar);
        end
      end
      prevDone = done;
    end else begin
      prevDone = 1'b0;
    end
  end

  initial begin
    int r, first;
    setPos(0, 0);
    doReset;
    check(busy == 1'b0, "R1", int'(busy), 0);
    check(done == 1'b0, "R1", int'(done), 0);
    check(charOut == 5'd0, "R1", int'(charOut), 0);

    // wheel arithmetic and stage order, identity plugboard
    sendChar(0, "R9", 0);  waitIdle;
    sendChar(25, "R10", 0); waitIdle;
    sendChar(13, "R9", 0); waitIdle;
    check(charOut == 5'(modelPass(13)), "R3", int'(charOut), modelPass(13));
    setPos(5, 19);
    sendChar(1, "R9", 0);  waitIdle;
    sendChar(24, "R10", 0); waitIdle;
    setPos(25, 25);
    sendChar(12, "R9", 0); waitIdle;

    // plugboard writes
    setPos(3, 11);
    plugPair(0, 4);
    plugPair(7, 12);
    plugWrEn = 1'b1; plugWrAddr = 5'd28; plugWrData = 5'd2;
    @(negedge clk);
    plugWrEn = 1'b0;
    sendChar(0, "R8", 0);  waitIdle;
    sendChar(4, "R8", 0);  waitIdle;
    sendChar(12, "R8", 0); waitIdle;
    sendChar(2, "R8", 0);  waitIdle;

    // reciprocity
    sendChar(7, "R5", 0); waitIdle;
    r = int'(charOut);
    sendChar(r, "R5", 0); waitIdle;
    check(charOut == 5'd7, "R5", int'(charOut), 7);

    // plugboard bypass
    plugEn = 1'b0;
    sendChar(0, "R7", 0);  waitIdle;
    sendChar(12, "R7", 0); waitIdle;
    plugEn = 1'b1;

    // strobe while busy
    sendChar(3, "R4", 0);
    repeat (5) @(negedge clk);
    pokeStrobe(20);
    repeat (4) @(negedge clk);
    pokeStrobe(9);
    waitIdle;
    repeat (30) @(negedge clk);
    check(extraDone == 0, "R4", extraDone, 0);

    // back-to-back stream
    setPos(8, 2);
    first = 1;
    for (int k = 0; k < 5; k++) begin
      sendChar((k * 5 + 1) % 26, "R11", first ? 1'b0 : 1'b1);
      first = 0;
    end
    waitIdle;

    // reset restores identity plugboard
    doReset;
    check(charOut == 5'd0, "R1", int'(charOut), 0);
    setPos(3, 11);
    sendChar(0, "R1", 0); waitIdle;
    sendChar(4, "R1", 0); waitIdle;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule